// File: doc/BRIEF.md
# AC Offset Calibration Unit

This block removes a small, steady noise floor from the RMS result of a current channel. It sits between the mean-square accumulator and the square-root stage. In normal operation every new mean-square sample has a stored offset subtracted from it. The difference is clamped at zero, and the corrected value is passed on to the square-root stage. The offset is kept as a squared quantity, with the same unsigned fixed-point format as the mean-square input. The largest RMS noise the block can cancel is therefore the square root of the largest value the offset register can hold.

Calibration is started by a one-cycle command while the current input is left open and the channel's high-pass filter is on. The command clears the offset register so that the old value cannot bias the measurement. The controller then lets a programmable number of conversion strobes pass, so that the filters can settle. That number is typically set to the strobe count that matches two seconds. The next strobe's raw mean-square value is written into the offset register, and a one-cycle done pulse follows. Software can read and write both the offset register and the settle-count register.

The controller has three states:
- `ST_IDLE` is the normal correction mode.
- `ST_SETTLE` discards strobes while counting down.
- `ST_CAPTURE` waits for the strobe that is stored as the offset.

It has four transitions:
- start-with-count: `ST_IDLE` to `ST_SETTLE`, on a start command with a non-zero settle count.
- start-no-settle: `ST_IDLE` to `ST_CAPTURE`, on a start command with a settle count of zero.
- settle-expired: `ST_SETTLE` to `ST_CAPTURE`, on the strobe that brings the count to zero.
- captured: `ST_CAPTURE` to `ST_IDLE`, on the strobe that is stored.

Top module: `acal_unit`

## Requirements
- R1: After reset the offset register reads 0 and the settle-count register reads its reset value (8000 by default). `corr_valid` and `cal_done` are low.
- R2: In `ST_IDLE`, each `ms_valid` strobe produces `corr_valid` high for one cycle on the following clock. With it comes `corr_data` = `ms_data` minus the offset register value as it was at the strobe. This also holds for a strobe in the same cycle as a start command.
- R3: When `ms_data` is less than or equal to the offset, `corr_data` is 0. The subtraction never wraps.
- R4: A start command in `ST_IDLE` clears the offset register, which reads 0 on the next cycle.
- R5: After a start, the first N `ms_valid` strobes are discarded, where N is the settle-count register value in the start cycle. The offset stays 0 and `cal_done` stays low during that time. When N = 0, the first strobe is the one captured.
- R6: The strobe that follows the settle phase has its raw `ms_data` (a squared value, not corrected) written into the offset register. `cal_done` is high for exactly the one cycle in which the new value first reads back, and the block returns to `ST_IDLE`.
- R7: From the start command until capture, `corr_valid` stays low.
- R8: While a calibration runs, further start commands and software writes to the offset register have no effect.
- R9: A software offset write in `ST_IDLE` reads back on the next cycle. A strobe in the same cycle as the write is corrected with the previous offset. A write in the same cycle as a start command loses to the clear.
- R10: The offset register holds the full input range. An all-ones offset is stored exactly, and an all-ones input corrected by it gives 0.
- R11: A settle-count write reads back on the next cycle at any time. It does not change the count of a calibration already started, including one started in the same cycle, but it applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_valid | input | 1 | Mean-square sample strobe |
| ms_data | input | MS_W | Mean-square sample, unsigned |
| cal_start | input | 1 | One-cycle calibration start command |
| off_wr | input | 1 | Software write strobe for the offset register |
| off_wdata | input | MS_W | Offset write value |
| off_rdata | output | MS_W | Offset register readback |
| settle_wr | input | 1 | Software write strobe for the settle count |
| settle_wdata | input | CNT_W | Settle count write value, in strobes |
| settle_rdata | output | CNT_W | Settle count readback |
| cal_done | output | 1 | One-cycle pulse when a captured offset is written |
| corr_valid | output | 1 | Corrected sample strobe |
| corr_data | output | MS_W | Offset-corrected mean-square sample |

## Verification
The bench targets the following corner cases, and states what a wrong design would do in each:
- Inputs at or below the offset, which includes an all-ones input against an all-ones offset. A design that wraps the subtraction would return a huge value instead of zero.
- Strobes that coincide with a start command or with a software offset write. A design with the wrong priority would correct the strobe with the new offset, or keep a written value over the clear.
- A settle count of zero, and a settle count rewritten in the middle of a run. An off-by-one counter would capture a discarded strobe or skip the intended one. A design that reads the count live would stretch or shorten a run already in progress.
- Restarts and offset writes during calibration. These must leave the capture untouched.

// File: rtl/acal_pkg.sv
package acal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_CAPTURE = 2'd2
    } acal_state_e;

endpackage

// File: rtl/acal_settle_ctr.sv
module acal_settle_ctr #(
    parameter int CNT_W      = 16,
    parameter int SETTLE_RST = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] cfg_val,
    output logic             cfg_zero,
    output logic             cnt_last
);

    localparam logic [CNT_W-1:0] CFG_INIT = CNT_W'(SETTLE_RST);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cfg_q;
    logic [CNT_W-1:0] cnt_q;

    // settle-count register, writable at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_INIT;
        end else if (cfg_wr) begin
            cfg_q <= cfg_wdata;
        end
    end

    // down-counter loaded from the register value held in the start cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cfg_q;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cfg_val  = cfg_q;
    assign cfg_zero = (cfg_q == '0);
    assign cnt_last = (cnt_q == ONE);

    // R11: a write is visible on the next cycle
    a_r11_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(cfg_wdata)))
        else $error("a_r11_cfg_write");

    // R5: the counter never wraps below zero
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && (cnt_q == '0)) |=> (cnt_q == '0))
        else $error("a_r5_no_wrap");

endmodule

// File: rtl/acal_offset_reg.sv
module acal_offset_reg #(
    parameter int MS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cap,
    input  logic [MS_W-1:0] cap_data,
    input  logic            sw_wr,
    input  logic [MS_W-1:0] sw_wdata,
    output logic [MS_W-1:0] off_val
);

    logic [MS_W-1:0] off_q;

    // priority: clear, then capture, then software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (clr) begin
            off_q <= '0;
        end else if (cap) begin
            off_q <= cap_data;
        end else if (sw_wr) begin
            off_q <= sw_wdata;
        end
    end

    assign off_val = off_q;

    // R4: a clear always leaves zero behind
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (off_q == '0))
        else $error("a_r4_clear_zero");

    // R6: a capture stores the raw sample
    a_r6_capture_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr) |=> (off_q == $past(cap_data)))
        else $error("a_r6_capture_raw");

endmodule

// File: rtl/acal_sub_clamp.sv
module acal_sub_clamp #(
    parameter int MS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [MS_W-1:0] in_data,
    input  logic [MS_W-1:0] off_val,
    output logic            out_valid,
    output logic [MS_W-1:0] out_data
);

    logic [MS_W:0]   diff;
    logic            under;
    logic [MS_W-1:0] clamped;

    always_comb begin
        diff    = {1'b0, in_data} - {1'b0, off_val};
        under   = diff[MS_W];
        clamped = under ? '0 : diff[MS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= clamped;
            end
        end
    end

    // R3: a corrected value never exceeds the sample it came from
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data <= $past(in_data)))
        else $error("a_r3_no_overflow");

    // R3: a sample at or below the offset gives zero
    a_r3_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_data <= off_val)) |=> (out_data == '0))
        else $error("a_r3_clamp_zero");

endmodule

// File: rtl/acal_fsm.sv
module acal_fsm
    import acal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cal_start,
    input  logic        ms_valid,
    input  logic        cfg_zero,
    input  logic        cnt_last,
    output acal_state_e state,
    output logic        ld_cnt,
    output logic        dec_cnt,
    output logic        clr_off,
    output logic        cap_off,
    output logic        sw_wr_en,
    output logic        pass,
    output logic        done
);

    acal_state_e state_q;
    acal_state_e state_d;
    logic        is_idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cal_start) begin
                    state_d = cfg_zero ? ST_CAPTURE : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (ms_valid && cnt_last) begin
                    state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (ms_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_idle  = (state_q == ST_IDLE);
        ld_cnt   = is_idle && cal_start;
        clr_off  = is_idle && cal_start;
        pass     = is_idle && ms_valid;
        sw_wr_en = is_idle;
        dec_cnt  = (state_q == ST_SETTLE) && ms_valid;
        cap_off  = (state_q == ST_CAPTURE) && ms_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= cap_off;
        end
    end

    assign state = state_q;

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("a_r6_done_pulse");

    // R6: done only follows the capture state, and the block is back in idle
    a_r6_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE))
        else $error("a_r6_done_after_capture");

    // R8: a start command during calibration does not restart the run
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CAPTURE) && !ms_valid) |=> (state_q == ST_CAPTURE))
        else $error("a_r8_no_restart");

endmodule

// File: rtl/acal_unit.sv
module acal_unit
    import acal_pkg::*;
#(
    parameter int MS_W       = 24,
    parameter int CNT_W      = 16,
    parameter int SETTLE_RST = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_valid,
    input  logic [MS_W-1:0]  ms_data,
    input  logic             cal_start,
    input  logic             off_wr,
    input  logic [MS_W-1:0]  off_wdata,
    output logic [MS_W-1:0]  off_rdata,
    input  logic             settle_wr,
    input  logic [CNT_W-1:0] settle_wdata,
    output logic [CNT_W-1:0] settle_rdata,
    output logic             cal_done,
    output logic             corr_valid,
    output logic [MS_W-1:0]  corr_data
);

    acal_state_e     state;
    logic            ld_cnt;
    logic            dec_cnt;
    logic            clr_off;
    logic            cap_off;
    logic            sw_wr_en;
    logic            pass;
    logic            cfg_zero;
    logic            cnt_last;
    logic [MS_W-1:0] off_val;

    acal_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .ms_valid  (ms_valid),
        .cfg_zero  (cfg_zero),
        .cnt_last  (cnt_last),
        .state     (state),
        .ld_cnt    (ld_cnt),
        .dec_cnt   (dec_cnt),
        .clr_off   (clr_off),
        .cap_off   (cap_off),
        .sw_wr_en  (sw_wr_en),
        .pass      (pass),
        .done      (cal_done)
    );

    acal_settle_ctr #(
        .CNT_W      (CNT_W),
        .SETTLE_RST (SETTLE_RST)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (settle_wr),
        .cfg_wdata (settle_wdata),
        .load      (ld_cnt),
        .dec       (dec_cnt),
        .cfg_val   (settle_rdata),
        .cfg_zero  (cfg_zero),
        .cnt_last  (cnt_last)
    );

    acal_offset_reg #(
        .MS_W (MS_W)
    ) u_offset (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_off),
        .cap      (cap_off),
        .cap_data (ms_data),
        .sw_wr    (off_wr && sw_wr_en),
        .sw_wdata (off_wdata),
        .off_val  (off_val)
    );

    acal_sub_clamp #(
        .MS_W (MS_W)
    ) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pass),
        .in_data   (ms_data),
        .off_val   (off_val),
        .out_valid (corr_valid),
        .out_data  (corr_data)
    );

    assign off_rdata = off_val;

    // R7: no corrected output while calibrating
    a_r7_quiet_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !corr_valid)
        else $error("a_r7_quiet_in_cal");

    // R8: offset is frozen during the settle phase
    a_r8_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> $stable(off_rdata))
        else $error("a_r8_offset_frozen");

    // R5: done never rises while settling
    a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> !cal_done)
        else $error("a_r5_no_early_done");

endmodule

// File: tb/acal_unit_tb.sv
module acal_unit_tb_top;

    localparam int MS_W  = 24;
    localparam int CNT_W = 16;
    localparam longint MAXV = (longint'(1) << MS_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_valid = 1'b0;
    logic [MS_W-1:0]  ms_data = '0;
    logic             cal_start = 1'b0;
    logic             off_wr = 1'b0;
    logic [MS_W-1:0]  off_wdata = '0;
    logic [MS_W-1:0]  off_rdata;
    logic             settle_wr = 1'b0;
    logic [CNT_W-1:0] settle_wdata = '0;
    logic [CNT_W-1:0] settle_rdata;
    logic             cal_done;
    logic             corr_valid;
    logic [MS_W-1:0]  corr_data;

    always #4 clk = ~clk;

    acal_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_valid     (ms_valid),
        .ms_data      (ms_data),
        .cal_start    (cal_start),
        .off_wr       (off_wr),
        .off_wdata    (off_wdata),
        .off_rdata    (off_rdata),
        .settle_wr    (settle_wr),
        .settle_wdata (settle_wdata),
        .settle_rdata (settle_rdata),
        .cal_done     (cal_done),
        .corr_valid   (corr_valid),
        .corr_data    (corr_data)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    run_cmp = 1'b0;
    int    cyc_cnt = 0;
    bit    finished = 1'b0;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle, 1 settling, 2 waiting for capture
    int     m_state = 0;
    longint m_off = 0;
    longint m_cfg = 8000;
    longint m_cnt = 0;
    bit     e_valid = 1'b0;
    bit     e_done = 1'b0;
    longint e_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_off = 0; m_cfg = 8000; m_cnt = 0;
            e_valid = 0; e_done = 0; e_data = 0;
        end else begin
            e_valid = 0;
            e_done  = 0;
            if (m_state == 0) begin
                if (ms_valid) begin
                    e_valid = 1;
                    e_data  = (longint'(ms_data) > m_off) ? longint'(ms_data) - m_off : 0;
                end
                if (cal_start) begin
                    m_off   = 0;
                    m_cnt   = m_cfg;
                    m_state = (m_cfg == 0) ? 2 : 1;
                end else if (off_wr) begin
                    m_off = longint'(off_wdata);
                end
            end else if (m_state == 1) begin
                if (ms_valid) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_state = 2;
                end
            end else begin
                if (ms_valid) begin
                    m_off   = longint'(ms_data);
                    e_done  = 1;
                    m_state = 0;
                end
            end
            if (settle_wr) m_cfg = longint'(settle_wdata);
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_cmp && !finished) begin
            check(cur_req, "corr_valid", longint'(corr_valid), longint'(e_valid));
            if (e_valid) check(cur_req, "corr_data", longint'(corr_data), e_data);
            check(cur_req, "cal_done", longint'(cal_done), longint'(e_done));
            check(cur_req, "off_rdata", longint'(off_rdata), m_off);
            check(cur_req, "settle_rdata", longint'(settle_rdata), m_cfg);
        end
    end

    task automatic cyc(bit v = 0, longint d = 0, bit st = 0, bit ow = 0,
                       longint owd = 0, bit sw = 0, longint swd = 0);
        @(negedge clk);
        ms_valid     = v;
        ms_data      = d[MS_W-1:0];
        cal_start    = st;
        off_wr       = ow;
        off_wdata    = owd[MS_W-1:0];
        settle_wr    = sw;
        settle_wdata = swd[CNT_W-1:0];
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "off_rdata", longint'(off_rdata), 0);
        check("R1", "settle_rdata", longint'(settle_rdata), 8000);
        check("R1", "corr_valid", longint'(corr_valid), 0);
        check("R1", "cal_done", longint'(cal_done), 0);
        run_cmp = 1'b1;

        // R2 plain correction with zero offset
        cur_req = "R2";
        cyc(1, 100); cyc();
        check("R2", "corr_valid", longint'(corr_valid), 1);
        check("R2", "corr_data", longint'(corr_data), 100);

        // R9 write with a same-cycle strobe uses the old offset
        cur_req = "R9";
        cyc(1, 1000, 0, 1, 300); cyc();
        check("R9", "corr_data", longint'(corr_data), 1000);
        check("R9", "off_rdata", longint'(off_rdata), 300);
        cyc(1, 1000); cyc();
        check("R2", "corr_data", longint'(corr_data), 700);

        // R3 clamp at and below the offset
        cur_req = "R3";
        cyc(1, 300); cyc();
        check("R3", "corr_data", longint'(corr_data), 0);
        cyc(1, 200); cyc();
        check("R3", "corr_data", longint'(corr_data), 0);
        cyc(1, 301); cyc();
        check("R3", "corr_data", longint'(corr_data), 1);

        // R4 start clears the offset; R11 count written first
        cur_req = "R4";
        cyc(0, 0, 0, 0, 0, 1, 3);
        cyc(0, 0, 1); cyc();
        check("R4", "off_rdata", longint'(off_rdata), 0);

        // R5 three strobes discarded, R7 quiet, R8 restart/write ignored
        cur_req = "R5";
        cyc(1, 11); cyc(); cyc(1, 12); cyc(1, 13); cyc();
        check("R5", "cal_done", longint'(cal_done), 0);
        check("R7", "corr_valid", longint'(corr_valid), 0);
        cur_req = "R8";
        cyc(0, 0, 1, 1, 777); cyc();
        check("R8", "off_rdata", longint'(off_rdata), 0);
        cur_req = "R6";
        cyc(1, 4321); cyc();
        check("R6", "cal_done", longint'(cal_done), 1);
        check("R6", "off_rdata", longint'(off_rdata), 4321);
        cyc();
        check("R6", "cal_done", longint'(cal_done), 0);

        // R11 count rewritten mid-run applies to the next run only
        cur_req = "R11";
        cyc(0, 0, 0, 0, 0, 1, 2);
        cyc(0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1, 5);
        cyc(1, 9); cyc(1, 9); cyc(1, 55); cyc();
        check("R11", "off_rdata", longint'(off_rdata), 55);
        check("R11", "cal_done", longint'(cal_done), 1);
        cyc(0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 9);
        cyc();
        check("R11", "off_rdata", longint'(off_rdata), 0);
        cyc(1, 66); cyc();
        check("R11", "off_rdata", longint'(off_rdata), 66);

        // R5 zero settle count captures the first strobe
        cur_req = "R5";
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 1);
        cyc(1, 2024); cyc();
        check("R5", "off_rdata", longint'(off_rdata), 2024);
        check("R5", "cal_done", longint'(cal_done), 1);

        // R10 full-range offset
        cur_req = "R10";
        cyc(0, 0, 0, 1, MAXV);
        cyc(1, MAXV); cyc();
        check("R10", "corr_data", longint'(corr_data), 0);
        check("R10", "off_rdata", longint'(off_rdata), MAXV);
        cyc(0, 0, 1);
        cyc(1, MAXV); cyc();
        check("R10", "off_rdata", longint'(off_rdata), MAXV);

        // R2 strobe with start; R9 write with start loses to clear
        cur_req = "R2";
        cyc(0, 0, 0, 1, 10);
        cyc(1, 50, 1, 1, 99); cyc();
        check("R2", "corr_data", longint'(corr_data), 40);
        check("R9", "off_rdata", longint'(off_rdata), 0);
        cyc(1, 10); cyc();
        check("R6", "off_rdata", longint'(off_rdata), 10);

        // mixed traffic against the model
        cur_req = "R2";
        cyc(0, 0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 3000; i++) begin
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 4095),
                $urandom_range(0, 19) == 0, $urandom_range(0, 9) == 0,
                $urandom_range(0, 4095), $urandom_range(0, 29) == 0,
                $urandom_range(0, 3));
        end
        cyc(); cyc();
        summary();
    end

endmodule